// File: doc/BRIEF.md
# Merged Register Rename Unit

This unit maps architectural register names to entries of one shared physical register file. The same physical entry holds an instruction's result both while it is speculative and after it commits, so committing never copies data. Each physical entry is tracked in one of four states: free, allocated to an in-flight instruction, done (result written), or committed. The unit renames at most one instruction per cycle. For that instruction it returns the physical sources, a newly allocated physical destination, the mapping the destination replaces, and an 8-bit tag.

Four interfaces use it. Rename reads the map and allocates a destination. Complete marks a physical register done and echoes its number as a wake-up tag on the next cycle. Commit retires the oldest in-flight instruction: the replaced mapping is released and the new destination becomes committed. Recover rolls the map back to its contents just before a given tag was renamed, and it releases every destination that the squashed instructions allocated.

Up to 20 instructions can be in flight. Each one owns a history slot that holds the map snapshot taken before that instruction was renamed.

Top module: `rr_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i for i in 0..30, registers 0..30 are committed, 31..71 are free, `ren_ready` is 1, `ren_tag` is 0 and `bcast_valid` is 0.
- R2: `ren_psrc1`/`ren_psrc2` give the current mapping of the source registers. A source equal to the same instruction's destination sees the mapping from before that instruction.
- R3: The destination is the lowest-numbered free physical register. `ren_pold` is the destination's previous mapping. Once renamed, the register is no longer free.
- R4: `ren_tag` increases by one (mod 256) for each accepted rename. After an accepted recovery it equals the recovered tag.
- R5: A complete request for a register in the allocated state moves it to done and gives `bcast_valid`=1 with `bcast_preg` equal to that register one cycle later. A complete request for a register in any other state is ignored and gives `bcast_valid`=0.
- R6: A commit acts on the oldest in-flight instruction and only if its destination is done. The replaced register then becomes free and the destination becomes committed. Otherwise the commit is ignored.
- R7: `ren_ready` is 0 when 20 instructions are in flight or no register is free. A rename presented while `ren_ready` is 0 is ignored.
- R8: A recovery naming an in-flight tag restores the map to its contents just before that tag was renamed, and it frees the destinations of that instruction and of every younger one. A tag not in flight is ignored.
- R9: In a cycle with an accepted recovery, rename and commit requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_src1 | input | 5 | First source architectural register (0..30) |
| ren_src2 | input | 5 | Second source architectural register (0..30) |
| ren_dst | input | 5 | Destination architectural register (0..30) |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_psrc1 | output | 7 | Physical register of first source |
| ren_psrc2 | output | 7 | Physical register of second source |
| ren_pdst | output | 7 | Newly allocated physical destination |
| ren_pold | output | 7 | Previous mapping of the destination |
| ren_tag | output | 8 | Tag given to this instruction |
| cmp_valid | input | 1 | Complete request |
| cmp_preg | input | 7 | Physical register whose result was written |
| bcast_valid | output | 1 | Wake-up broadcast valid |
| bcast_preg | output | 7 | Broadcast physical register number |
| cmt_valid | input | 1 | Commit request for the oldest in-flight instruction |
| rcv_valid | input | 1 | Recovery request |
| rcv_tag | input | 8 | Tag of the first instruction to squash |

## Verification
The bench targets several corner cases:
- An instruction whose destination is also its source. A design that updated the map before reading it would return the new register.
- A commit while the oldest destination is still pending. A design that ignored the done check would release a register that is still live, and a later rename would then be handed that register too early.
- A recovery presented together with a rename and a commit. A design that let either through would show up as a wrong tag or a wrongly allocated register in the renames that follow.
- A recovery with a tag that is not in flight, and a rename attempted with all 20 history slots occupied. Each must leave the tag sequence and the allocation order untouched.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
  localparam int TAG_W = 8;

  typedef enum logic [1:0] {
    PR_FREE   = 2'd0,
    PR_RENAME = 2'd1,
    PR_DONE   = 2'd2,
    PR_COMMIT = 2'd3
  } preg_st_e;

  // position in a circular buffer of the given depth
  function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + off) % depth;
  endfunction

  // distance of a tag from the oldest in-flight tag, modulo the tag space
  function automatic logic [TAG_W-1:0] tag_gap(logic [TAG_W-1:0] t,
                                               logic [TAG_W-1:0] oldest);
    return t - oldest;
  endfunction
endpackage

// File: rtl/rr_freepick.sv
`timescale 1ns/1ps
module rr_freepick #(
  parameter int N = 72,
  parameter int W = 7
) (
  input  logic [N-1:0] avail,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (avail[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/rr_history.sv
`timescale 1ns/1ps
module rr_history
  import rr_pkg::*;
#(
  parameter int NA    = 31,
  parameter int NP    = 72,
  parameter int PW    = 7,
  parameter int DEPTH = 20,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [NA-1:0][PW-1:0]  push_map,
  input  logic [PW-1:0]          push_pd,
  input  logic [PW-1:0]          push_pold,
  input  logic                   pop,
  input  logic                   rcv_valid,
  input  logic [TAG_W-1:0]       rcv_tag,
  output logic [CW-1:0]          cnt,
  output logic [TAG_W-1:0]       nxt_tag,
  output logic [PW-1:0]          head_pd,
  output logic [PW-1:0]          head_pold,
  output logic                   rcv_hit,
  output logic [NA-1:0][PW-1:0]  rcv_map,
  output logic [NP-1:0]          rcv_squash
);
  logic [NA-1:0][PW-1:0] snap_q [DEPTH];
  logic [PW-1:0]         pd_q   [DEPTH];
  logic [PW-1:0]         pold_q [DEPTH];
  logic [IW-1:0]         head_q;
  logic [CW-1:0]         cnt_q;
  logic [TAG_W-1:0]      tag_q;
  logic [TAG_W-1:0]      head_tag, off;
  logic [IW-1:0]         sel, wr_idx;

  always_comb begin
    head_tag   = tag_q - TAG_W'(cnt_q);
    off        = tag_gap(rcv_tag, head_tag);
    rcv_hit    = rcv_valid && (int'(off) < int'(cnt_q));
    sel        = IW'(ring_add(int'(head_q), int'(off), DEPTH));
    wr_idx     = IW'(ring_add(int'(head_q), int'(cnt_q), DEPTH));
    rcv_map    = snap_q[sel];
    head_pd    = pd_q[head_q];
    head_pold  = pold_q[head_q];
    rcv_squash = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k >= int'(off) && k < int'(cnt_q))
        rcv_squash[pd_q[IW'(ring_add(int'(head_q), k, DEPTH))]] = 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign nxt_tag = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      tag_q  <= '0;
    end else if (rcv_hit) begin
      cnt_q <= CW'(off);
      tag_q <= rcv_tag;
    end else begin
      if (push) tag_q <= tag_q + 1'b1;
      if (pop)  head_q <= IW'(ring_add(int'(head_q), 1, DEPTH));
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !rcv_hit) begin
      snap_q[wr_idx] <= push_map;
      pd_q[wr_idx]   <= push_pd;
      pold_q[wr_idx] <= push_pold;
    end
  end
endmodule

// File: rtl/rr_rename_unit.sv
`timescale 1ns/1ps
module rr_rename_unit
  import rr_pkg::*;
#(
  parameter int NUM_ARCH   = 31,
  parameter int NUM_PHYS   = 72,
  parameter int HIST_DEPTH = 20,
  localparam int AW        = $clog2(NUM_ARCH),
  localparam int PW        = $clog2(NUM_PHYS),
  localparam int CW        = $clog2(HIST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_valid,
  input  logic [AW-1:0]    ren_src1,
  input  logic [AW-1:0]    ren_src2,
  input  logic [AW-1:0]    ren_dst,
  output logic             ren_ready,
  output logic [PW-1:0]    ren_psrc1,
  output logic [PW-1:0]    ren_psrc2,
  output logic [PW-1:0]    ren_pdst,
  output logic [PW-1:0]    ren_pold,
  output logic [TAG_W-1:0] ren_tag,
  input  logic             cmp_valid,
  input  logic [PW-1:0]    cmp_preg,
  output logic             bcast_valid,
  output logic [PW-1:0]    bcast_preg,
  input  logic             cmt_valid,
  input  logic             rcv_valid,
  input  logic [TAG_W-1:0] rcv_tag
);
  logic [NUM_ARCH-1:0][PW-1:0] map_q;
  preg_st_e                    st_q [NUM_PHYS];
  logic [NUM_PHYS-1:0]         avail_mask;
  logic                        free_found;
  logic [PW-1:0]               free_idx;
  logic [CW-1:0]               hist_cnt;
  logic [PW-1:0]               head_pd, head_pold;
  logic                        rcv_hit;
  logic [NUM_ARCH-1:0][PW-1:0] rcv_map;
  logic [NUM_PHYS-1:0]         rcv_squash;
  // named events, observed by the checker
  logic                        ren_fire, cmt_fire, cmp_fire;
  logic                        bcast_valid_q;
  logic [PW-1:0]               bcast_preg_q;

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_avail
    assign avail_mask[g] = (st_q[g] == PR_FREE);
  end

  rr_freepick #(.N(NUM_PHYS), .W(PW)) u_pick (
    .avail (avail_mask),
    .found (free_found),
    .idx   (free_idx)
  );

  rr_history #(.NA(NUM_ARCH), .NP(NUM_PHYS), .PW(PW), .DEPTH(HIST_DEPTH)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ren_fire),
    .push_map   (map_q),
    .push_pd    (free_idx),
    .push_pold  (ren_pold),
    .pop        (cmt_fire),
    .rcv_valid  (rcv_valid),
    .rcv_tag    (rcv_tag),
    .cnt        (hist_cnt),
    .nxt_tag    (ren_tag),
    .head_pd    (head_pd),
    .head_pold  (head_pold),
    .rcv_hit    (rcv_hit),
    .rcv_map    (rcv_map),
    .rcv_squash (rcv_squash)
  );

  assign ren_ready = free_found && (hist_cnt < CW'(HIST_DEPTH));
  assign ren_psrc1 = map_q[ren_src1];
  assign ren_psrc2 = map_q[ren_src2];
  assign ren_pdst  = free_idx;
  assign ren_pold  = map_q[ren_dst];
  assign ren_fire  = ren_valid && ren_ready && !rcv_hit;
  assign cmt_fire  = cmt_valid && (hist_cnt != '0) && (st_q[head_pd] == PR_DONE) && !rcv_hit;
  assign cmp_fire  = cmp_valid && (int'(cmp_preg) < NUM_PHYS) && (st_q[cmp_preg] == PR_RENAME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        st_q[i] <= (i < NUM_ARCH) ? PR_COMMIT : PR_FREE;
      for (int i = 0; i < NUM_ARCH; i++)
        map_q[i] <= PW'(i);
    end else begin
      if (cmp_fire) st_q[cmp_preg] <= PR_DONE;
      if (cmt_fire) begin
        st_q[head_pd]   <= PR_COMMIT;
        st_q[head_pold] <= PR_FREE;
      end
      if (ren_fire) begin
        st_q[free_idx] <= PR_RENAME;
        map_q[ren_dst] <= free_idx;
      end
      if (rcv_hit) begin
        for (int i = 0; i < NUM_PHYS; i++)
          if (rcv_squash[i]) st_q[i] <= PR_FREE;
        map_q <= rcv_map;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcast_valid_q <= 1'b0;
      bcast_preg_q  <= '0;
    end else begin
      bcast_valid_q <= cmp_fire;
      bcast_preg_q  <= cmp_preg;
    end
  end

  assign bcast_valid = bcast_valid_q;
  assign bcast_preg  = bcast_preg_q;
endmodule

// File: rtl/rr_rename_chk.sv
`timescale 1ns/1ps
module rr_rename_chk #(
  parameter int NUM_ARCH   = 31,
  parameter int NUM_PHYS   = 72,
  parameter int HIST_DEPTH = 20,
  localparam int PW        = $clog2(NUM_PHYS),
  localparam int CW        = $clog2(HIST_DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ren_fire,
  input logic                ren_ready,
  input logic [PW-1:0]       ren_pdst,
  input logic [NUM_PHYS-1:0] avail_mask,
  input logic [CW-1:0]       hist_cnt,
  input logic                cmp_fire,
  input logic [PW-1:0]       cmp_preg,
  input logic                bcast_valid,
  input logic [PW-1:0]       bcast_preg
);
  AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |-> avail_mask[ren_pdst]); // R3
  AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |=> !avail_mask[$past(ren_pdst)]); // R3
  AST_HIST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hist_cnt) <= HIST_DEPTH); // R7
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hist_cnt) == HIST_DEPTH) |-> !ren_ready); // R7
  AST_BCAST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> (bcast_valid && bcast_preg == $past(cmp_preg))); // R5
  AST_BCAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> !bcast_valid); // R5
  AST_REG_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(avail_mask) + int'(hist_cnt)) == (NUM_PHYS - NUM_ARCH)); // R8
endmodule

bind rr_rename_unit rr_rename_chk #(
  .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .HIST_DEPTH(HIST_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ren_fire   (ren_fire),
  .ren_ready  (ren_ready),
  .ren_pdst   (ren_pdst),
  .avail_mask (avail_mask),
  .hist_cnt   (hist_cnt),
  .cmp_fire   (cmp_fire),
  .cmp_preg   (cmp_preg),
  .bcast_valid(bcast_valid),
  .bcast_preg (bcast_preg)
);

// File: tb/sim_rr_rename_unit.sv
`timescale 1ns/1ps
module sim_rr_rename_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 1'b0;
  logic [4:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
  logic       ren_ready;
  logic [6:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
  logic [7:0] ren_tag;
  logic       cmp_valid = 1'b0;
  logic [6:0] cmp_preg = '0;
  logic       bcast_valid;
  logic [6:0] bcast_preg;
  logic       cmt_valid = 1'b0;
  logic       rcv_valid = 1'b0;
  logic [7:0] rcv_tag = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rr_rename_unit u0 (.*);

  typedef struct packed {
    logic [4:0] s1, s2, d;
    logic [6:0] e1, e2, ed, eo;
    logic [7:0] et;
  } vec_t;

  // rename vectors from reset: sources, destination, expected outputs
  localparam vec_t VECS [4] = '{
    '{s1:5'd1, s2:5'd2,  d:5'd1, e1:7'd1,  e2:7'd2,  ed:7'd31, eo:7'd1,  et:8'd0},
    '{s1:5'd1, s2:5'd1,  d:5'd1, e1:7'd31, e2:7'd31, ed:7'd32, eo:7'd31, et:8'd1},
    '{s1:5'd5, s2:5'd30, d:5'd5, e1:7'd5,  e2:7'd30, ed:7'd33, eo:7'd5,  et:8'd2},
    '{s1:5'd5, s2:5'd1,  d:5'd7, e1:7'd33, e2:7'd32, ed:7'd34, eo:7'd7,  et:8'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_ren(input int s1, input int s2, input int d, input int e1,
                        input int e2, input int ed, input int eo, input int et,
                        input string req);
    @(negedge clk);
    ren_valid = 1'b1; ren_src1 = 5'(s1); ren_src2 = 5'(s2); ren_dst = 5'(d);
    #2;
    if (e1 >= 0) chk({req, " psrc1"}, int'(ren_psrc1), e1);
    if (e2 >= 0) chk({req, " psrc2"}, int'(ren_psrc2), e2);
    if (ed >= 0) chk({req, " pdst"}, int'(ren_pdst), ed);
    if (eo >= 0) chk({req, " pold"}, int'(ren_pold), eo);
    if (et >= 0) chk({req, " tag"}, int'(ren_tag), et);
    @(posedge clk); #1;
    ren_valid = 1'b0;
  endtask

  task automatic do_cmp(input int p, input int exp_bc, input string req);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_preg = 7'(p);
    @(posedge clk); #1;
    cmp_valid = 1'b0;
    @(negedge clk);
    chk({req, " bcast_valid"}, int'(bcast_valid), exp_bc);
    if (exp_bc != 0) chk({req, " bcast_preg"}, int'(bcast_preg), p);
  endtask

  task automatic do_cmt;
    @(negedge clk);
    cmt_valid = 1'b1;
    @(posedge clk); #1;
    cmt_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state seen through the rename outputs
    @(negedge clk);
    ren_src1 = 5'd30; ren_src2 = 5'd0; ren_dst = 5'd12;
    #2;
    chk("R1 ready", int'(ren_ready), 1);
    chk("R1 psrc1", int'(ren_psrc1), 30);
    chk("R1 psrc2", int'(ren_psrc2), 0);
    chk("R1 pdst", int'(ren_pdst), 31);
    chk("R1 pold", int'(ren_pold), 12);
    chk("R1 tag", int'(ren_tag), 0);
    chk("R1 bcast", int'(bcast_valid), 0);

    // R2 R3 R4: table of renames
    for (int i = 0; i < 4; i++)
      do_ren(VECS[i].s1, VECS[i].s2, VECS[i].d, VECS[i].e1, VECS[i].e2,
             VECS[i].ed, VECS[i].eo, VECS[i].et, "R2/R3 vec");

    do_cmt;                              // R6: head pd31 still pending, ignored
    do_cmp(31, 1, "R5 complete");
    do_cmp(31, 0, "R5 repeat complete");
    do_cmp(50, 0, "R5 free reg complete");
    do_cmt;                              // R6: accepted, frees 1
    do_cmt;                              // R6: head pd32 pending, ignored
    do_ren(1, 7, 2, 32, 34, 1, 2, 4, "R6 freed reg reused");
    do_ren(2, 0, 9, 1, 0, 35, 9, 5, "R6 ignored commit");
    do_cmp(32, 1, "R5 complete 32");

    // R8 R9: recover to tag 3 with rename and commit also requested
    @(negedge clk);
    rcv_valid = 1'b1; rcv_tag = 8'd3; ren_valid = 1'b1; cmt_valid = 1'b1;
    ren_src1 = 5'd0; ren_src2 = 5'd0; ren_dst = 5'd20;
    @(posedge clk); #1;
    rcv_valid = 1'b0; ren_valid = 1'b0; cmt_valid = 1'b0;
    do_ren(7, 2, 9, 7, 2, 1, 9, 3, "R8/R9 map restore");
    do_ren(1, 5, 3, 32, 33, 34, 3, 4, "R9 commit held");

    // R8: tag not in flight is ignored
    @(negedge clk);
    rcv_valid = 1'b1; rcv_tag = 8'd200;
    @(posedge clk); #1;
    rcv_valid = 1'b0;
    do_ren(9, 3, 4, 1, 34, 35, 4, 5, "R8 stray tag");

    // R7: fill the history
    for (int i = 0; i < 15; i++)
      do_ren(0, 0, 10, -1, -1, 36 + i, -1, 6 + i, "R7 fill");
    @(negedge clk); #2;
    chk("R7 full ready", int'(ren_ready), 0);
    do_ren(0, 0, 11, -1, -1, -1, -1, 21, "R7 stalled tag");
    do_cmt;                              // head tag1 done: frees 31
    @(negedge clk); #2;
    chk("R7 ready after commit", int'(ren_ready), 1);
    do_ren(0, 0, 11, -1, -1, 31, 11, 21, "R4/R6 after stall");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule